// File: doc/BRIEF.md
# UART Channel Interrupt Prioritizer

This block gathers every interrupt condition of one UART channel and decides which of them the processor should hear about. Each condition is latched until its own clearing event arrives, is gated by a per-level enable bit, and competes in a fixed six-level priority order. The winner drives one interrupt line and is reported as a 6-bit identification code that software reads through the identification register.

Condition inputs are single-cycle event pulses, with two exceptions: the receive error level, which stays high while any errored character is still queued, and the two active-low flow-control pins, which the block edge-detects itself. Register accesses reach the block as one-cycle strobes. The identification code is registered on the identification-read strobe. The same clock edge clears any source whose clearing rule is "reported by that read".

Top module: `uart_irq_prio`

## Requirements
- R1: Out of reset, and whenever no enabled source is pending, `irqOut` is low and the identification code is 000001; `iirData` resets to 000001.
- R2: Line status (level 1, code 000110) is pending while `rxErrLvl` is high or an `overrunEvt` has been latched. The latched overrun clears on `lsrRd`. A read of the identification register does not clear it.
- R3: Receiver timeout (code 001100) and receive-data (code 000100) share level 2, and timeout is reported first. Both are latched from their pulses and both clear on `rhrRd`, not on an identification read.
- R4: Transmit-empty (level 3, code 000010) clears on `thrWr`, or on an `iirRd` whose captured code is 000010.
- R5: Modem status (level 4, code 000000) clears only on `msrRd`.
- R6: An `xoffEvt` raises the level-5 source (code 010000). It clears on `xonEvt`, and neither `iirRd` nor `lsrRd` clears it.
- R7: A `specialEvt` raises the same level-5 source, and that cause clears on `lsrRd`.
- R8: A low-to-high transition on either bit of `flowPinN` (bit 0 CTS, bit 1 RTS, both active low) raises level 6 (code 100000). It clears on an `iirRd` whose captured code is 100000.
- R9: The reported code follows the fixed order line status, timeout, receive-data, transmit-empty, modem, Xoff/special, pin change.
- R10: `ierBits` holds one enable per level: bit 0 line status, bit 1 receive (timeout and data), bit 2 transmit-empty, bit 3 modem, bit 4 Xoff/special, bit 5 pin change. A disabled source does not assert `irqOut` and is not reported. It stays latched, an identification read does not clear it, and it reappears once it is re-enabled.
- R11: `iirData` changes only on `iirRd`, to the code that was live before that edge. A source event in the same cycle as a read that clears that source is kept, and a source arriving during a read is reported by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ierBits | input | 6 | Per-level interrupt enables |
| rxErrLvl | input | 1 | Errored character present in receive queue (level) |
| overrunEvt | input | 1 | Overrun detected (pulse) |
| rxToEvt | input | 1 | Receive timeout (pulse) |
| rxDatEvt | input | 1 | Receive data available / threshold reached (pulse) |
| txEmptyEvt | input | 1 | Transmit holding empty / threshold passed (pulse) |
| modemEvt | input | 1 | Modem status change (pulse) |
| xoffEvt | input | 1 | Xoff character detected (pulse) |
| xonEvt | input | 1 | Xon character detected (pulse) |
| specialEvt | input | 1 | Special character detected (pulse) |
| flowPinN | input | 2 | Flow-control pins, active low (bit 0 CTS, bit 1 RTS) |
| iirRd | input | 1 | Identification register read strobe |
| rhrRd | input | 1 | Receive holding register read strobe |
| thrWr | input | 1 | Transmit holding register write strobe |
| msrRd | input | 1 | Modem status register read strobe |
| lsrRd | input | 1 | Line status register read strobe |
| irqOut | output | 1 | Interrupt request, active high |
| iirData | output | 6 | Identification code captured on the last read |

## Verification
The hardest case to reach from the ports is a read that clears one source in the same edge where another source, or the same one, gets set. Reaching it needs a pulse that lines up exactly with the read strobe. The stimulus table puts both in one vector and then issues a follow-up read to show that nothing was lost. A second hard case is a source that stays hidden because it is disabled or outranked. The table covers it by reading while that source is hidden, then enabling it or removing the higher source, and showing that it is still pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ID_W    = 6;
  localparam int NUM_LVL = 6;

  // Enable bit positions, one per priority level
  localparam int EN_LINE   = 0;
  localparam int EN_RX     = 1;
  localparam int EN_TX     = 2;
  localparam int EN_MODEM  = 3;
  localparam int EN_FLOWCH = 4;
  localparam int EN_PIN    = 5;

  // Identification codes
  localparam logic [ID_W-1:0] ID_NONE   = 6'b000001;
  localparam logic [ID_W-1:0] ID_LINE   = 6'b000110;
  localparam logic [ID_W-1:0] ID_RXTO   = 6'b001100;
  localparam logic [ID_W-1:0] ID_RXDAT  = 6'b000100;
  localparam logic [ID_W-1:0] ID_TXE    = 6'b000010;
  localparam logic [ID_W-1:0] ID_MODEM  = 6'b000000;
  localparam logic [ID_W-1:0] ID_FLOWCH = 6'b010000;
  localparam logic [ID_W-1:0] ID_PINCHG = 6'b100000;

  // Latched source state seen by the control
  typedef struct packed {
    logic line;
    logic rxTo;
    logic rxDat;
    logic txE;
    logic modem;
    logic flowCh;
    logic pinChg;
  } pend_t;

  // Clear strobes from control to datapath
  typedef struct packed {
    logic rxClr;
    logic txClr;
    logic modemClr;
    logic lsrClr;
    logic pinClr;
  } clr_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LINE, SEL_RXTO, SEL_RXDAT,
    SEL_TXE, SEL_MODEM, SEL_FLOWCH, SEL_PINCHG
  } sel_e;

endpackage

// File: rtl/irq_src_dp.sv
module irq_src_dp
  import uart_irq_pkg::*;
#(
  parameter int FLOW_PINS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxErrLvl,
  input  logic                 overrunEvt,
  input  logic                 rxToEvt,
  input  logic                 rxDatEvt,
  input  logic                 txEmptyEvt,
  input  logic                 modemEvt,
  input  logic                 xoffEvt,
  input  logic                 xonEvt,
  input  logic                 specialEvt,
  input  logic [FLOW_PINS-1:0] flowPinN,
  input  clr_t                 clr,
  output pend_t                pend
);

  logic overrunQ, rxToQ, rxDatQ, txEQ, modemQ, xoffQ, specialQ, pinQ;
  logic [FLOW_PINS-1:0] pinPrevQ;
  logic [FLOW_PINS-1:0] pinRise;

  // Edge detection per flow pin: inactive (high) after active (low)
  for (genvar p = 0; p < FLOW_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pinPrevQ[p] <= 1'b1;
      else       pinPrevQ[p] <= flowPinN[p];
    end
    assign pinRise[p] = flowPinN[p] & ~pinPrevQ[p];
  end

  // Each latch: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
      rxToQ    <= 1'b0;
      rxDatQ   <= 1'b0;
      txEQ     <= 1'b0;
      modemQ   <= 1'b0;
      xoffQ    <= 1'b0;
      specialQ <= 1'b0;
      pinQ     <= 1'b0;
    end else begin
      overrunQ <= overrunEvt | (overrunQ & ~clr.lsrClr);
      rxToQ    <= rxToEvt    | (rxToQ    & ~clr.rxClr);
      rxDatQ   <= rxDatEvt   | (rxDatQ   & ~clr.rxClr);
      txEQ     <= txEmptyEvt | (txEQ     & ~clr.txClr);
      modemQ   <= modemEvt   | (modemQ   & ~clr.modemClr);
      xoffQ    <= xoffEvt    | (xoffQ    & ~xonEvt);
      specialQ <= specialEvt | (specialQ & ~clr.lsrClr);
      pinQ     <= (|pinRise) | (pinQ     & ~clr.pinClr);
    end
  end

  always_comb begin
    pend.line   = rxErrLvl | overrunQ;
    pend.rxTo   = rxToQ;
    pend.rxDat  = rxDatQ;
    pend.txE    = txEQ;
    pend.modem  = modemQ;
    pend.flowCh = xoffQ | specialQ;
    pend.pinChg = pinQ;
  end

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clr.rxClr && !rxToEvt && !rxDatEvt) |=> (!pend.rxTo && !pend.rxDat));

  // R4
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clr.txClr && !txEmptyEvt) |=> !pend.txE);

  // R5
  modem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend.modem && !clr.modemClr) |=> pend.modem);

  // R6
  xon_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xonEvt && !xoffEvt && !specialEvt && !specialQ) |=> !pend.flowCh);

  // R11
  event_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyEvt |=> pend.txE);

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  pend_t              pend,
  input  logic [NUM_LVL-1:0] ierBits,
  input  logic               iirRd,
  input  logic               rhrRd,
  input  logic               thrWr,
  input  logic               msrRd,
  input  logic               lsrRd,
  output clr_t               clr,
  output logic               irqOut,
  output logic [ID_W-1:0]    iirData
);

  pend_t           masked;
  sel_e            sel;
  logic [ID_W-1:0] liveCode;

  always_comb begin
    masked.line   = pend.line   & ierBits[EN_LINE];
    masked.rxTo   = pend.rxTo   & ierBits[EN_RX];
    masked.rxDat  = pend.rxDat  & ierBits[EN_RX];
    masked.txE    = pend.txE    & ierBits[EN_TX];
    masked.modem  = pend.modem  & ierBits[EN_MODEM];
    masked.flowCh = pend.flowCh & ierBits[EN_FLOWCH];
    masked.pinChg = pend.pinChg & ierBits[EN_PIN];
  end

  // Fixed priority chain
  always_comb begin
    if      (masked.line)   sel = SEL_LINE;
    else if (masked.rxTo)   sel = SEL_RXTO;
    else if (masked.rxDat)  sel = SEL_RXDAT;
    else if (masked.txE)    sel = SEL_TXE;
    else if (masked.modem)  sel = SEL_MODEM;
    else if (masked.flowCh) sel = SEL_FLOWCH;
    else if (masked.pinChg) sel = SEL_PINCHG;
    else                    sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_LINE:   liveCode = ID_LINE;
      SEL_RXTO:   liveCode = ID_RXTO;
      SEL_RXDAT:  liveCode = ID_RXDAT;
      SEL_TXE:    liveCode = ID_TXE;
      SEL_MODEM:  liveCode = ID_MODEM;
      SEL_FLOWCH: liveCode = ID_FLOWCH;
      SEL_PINCHG: liveCode = ID_PINCHG;
      default:    liveCode = ID_NONE;
    endcase
  end

  assign irqOut = |masked;

  always_comb begin
    clr.rxClr    = rhrRd;
    clr.txClr    = thrWr | (iirRd && sel == SEL_TXE);
    clr.modemClr = msrRd;
    clr.lsrClr   = lsrRd;
    clr.pinClr   = iirRd && sel == SEL_PINCHG;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      iirData <= ID_NONE;
    else if (iirRd) iirData <= liveCode;
  end

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> liveCode == ID_NONE);

  // R9
  line_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend.line && ierBits[EN_LINE]) |-> liveCode == ID_LINE);

  // R3
  timeout_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend.rxTo && ierBits[EN_RX] && !(pend.line && ierBits[EN_LINE]))
      |-> liveCode == ID_RXTO);

  // R10
  tx_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ierBits[EN_TX] |-> liveCode != ID_TXE);

  // R11
  iir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !iirRd |=> $stable(iirData));

  // R8
  pin_clear_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr.pinClr |-> (iirRd && !masked.line && !masked.flowCh));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int FLOW_PINS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LVL-1:0]   ierBits,
  input  logic                 rxErrLvl,
  input  logic                 overrunEvt,
  input  logic                 rxToEvt,
  input  logic                 rxDatEvt,
  input  logic                 txEmptyEvt,
  input  logic                 modemEvt,
  input  logic                 xoffEvt,
  input  logic                 xonEvt,
  input  logic                 specialEvt,
  input  logic [FLOW_PINS-1:0] flowPinN,
  input  logic                 iirRd,
  input  logic                 rhrRd,
  input  logic                 thrWr,
  input  logic                 msrRd,
  input  logic                 lsrRd,
  output logic                 irqOut,
  output logic [ID_W-1:0]      iirData
);

  pend_t pend;
  clr_t  clr;

  irq_src_dp #(.FLOW_PINS(FLOW_PINS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxErrLvl   (rxErrLvl),
    .overrunEvt (overrunEvt),
    .rxToEvt    (rxToEvt),
    .rxDatEvt   (rxDatEvt),
    .txEmptyEvt (txEmptyEvt),
    .modemEvt   (modemEvt),
    .xoffEvt    (xoffEvt),
    .xonEvt     (xonEvt),
    .specialEvt (specialEvt),
    .flowPinN   (flowPinN),
    .clr        (clr),
    .pend       (pend)
  );

  irq_ctl i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .pend    (pend),
    .ierBits (ierBits),
    .iirRd   (iirRd),
    .rhrRd   (rhrRd),
    .thrWr   (thrWr),
    .msrRd   (msrRd),
    .lsrRd   (lsrRd),
    .clr     (clr),
    .irqOut  (irqOut),
    .iirData (iirData)
  );

endmodule

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;

  // evt order: line lvl, overrun, timeout, rxdata, txempty, modem, xoff, xon, special
  // stb order: iirRd, rhrRd, thrWr, msrRd, lsrRd
  typedef struct packed {
    logic [5:0] ier;
    logic [8:0] evt;
    logic [1:0] pinN;
    logic [4:0] stb;
    logic       expIrq;
    logic [5:0] expId;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VECS [NV] = '{
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b000001, 4'd1},  // R1 idle read
    '{6'h3F, 9'b000010000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd4},  // R4
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b000010, 4'd4},  // R4 read clears
    '{6'h3F, 9'b000010000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd4},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00100, 1'b0, 6'b000000, 4'd4},  // R4 thr write clears
    '{6'h3F, 9'b001100000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd3},  // R3
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b001100, 4'd3},  // R3 timeout first
    '{6'h3F, 9'b000000000, 2'b11, 5'b01000, 1'b0, 6'b000000, 4'd3},  // R3 rhr clears both
    '{6'h3F, 9'b000100000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd3},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000100, 4'd3},
    '{6'h3F, 9'b000000000, 2'b11, 5'b01000, 1'b0, 6'b000000, 4'd3},
    '{6'h3F, 9'b000011000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd9},  // R9 tx + modem
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000010, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000000, 4'd5},  // R5 read keeps modem
    '{6'h3F, 9'b000000000, 2'b11, 5'b00010, 1'b0, 6'b000000, 4'd5},
    '{6'h3F, 9'b000000100, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd6},  // R6
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b010000, 4'd6},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00001, 1'b1, 6'b000000, 4'd6},  // R6 lsr keeps xoff
    '{6'h3F, 9'b000000010, 2'b11, 5'b00000, 1'b0, 6'b000000, 4'd6},  // R6 xon clears
    '{6'h3F, 9'b000000001, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd7},  // R7
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b010000, 4'd7},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00001, 1'b0, 6'b000000, 4'd7},  // R7 lsr clears
    '{6'h3F, 9'b000000000, 2'b01, 5'b00000, 1'b0, 6'b000000, 4'd8},  // R8 rts active
    '{6'h3F, 9'b000000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd8},  // R8 rts inactive
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b100000, 4'd8},
    '{6'h3F, 9'b000000000, 2'b10, 5'b00000, 1'b0, 6'b000000, 4'd8},  // R8 cts active
    '{6'h3F, 9'b000000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd8},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b100000, 4'd8},
    '{6'h3F, 9'b010000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd2},  // R2 overrun
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000110, 4'd2},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00001, 1'b0, 6'b000000, 4'd2},
    '{6'h3F, 9'b100000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd2},  // R2 error level
    '{6'h3F, 9'b100000000, 2'b11, 5'b10000, 1'b1, 6'b000110, 4'd2},
    '{6'h3F, 9'b100000000, 2'b11, 5'b00001, 1'b1, 6'b000000, 4'd2},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00000, 1'b0, 6'b000000, 4'd2},
    '{6'h00, 9'b000010000, 2'b11, 5'b00000, 1'b0, 6'b000000, 4'd10}, // R10 masked
    '{6'h00, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b000001, 4'd10},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd10},
    '{6'h3B, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b000001, 4'd10},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b000010, 4'd10},
    '{6'h3F, 9'b000010000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd11}, // R11
    '{6'h3F, 9'b000001000, 2'b11, 5'b10000, 1'b1, 6'b000010, 4'd11}, // R11 modem during read
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000000, 4'd11},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00010, 1'b0, 6'b000000, 4'd11},
    '{6'h3F, 9'b000010000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd11},
    '{6'h3F, 9'b000010000, 2'b11, 5'b10000, 1'b1, 6'b000010, 4'd11}, // R11 set beats clear
    '{6'h3F, 9'b000000000, 2'b11, 5'b00100, 1'b0, 6'b000000, 4'd11},
    '{6'h3F, 9'b011011100, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd9},  // R9 many at once
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000110, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00001, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b001100, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b01000, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000010, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b00010, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b010000, 4'd9},
    '{6'h3F, 9'b000000010, 2'b11, 5'b00000, 1'b0, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000100, 2'b01, 5'b00000, 1'b1, 6'b000000, 4'd9},  // R9 xoff over pin
    '{6'h3F, 9'b000000000, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b1, 6'b010000, 4'd9},
    '{6'h3F, 9'b000000010, 2'b11, 5'b00000, 1'b1, 6'b000000, 4'd9},
    '{6'h3F, 9'b000000000, 2'b11, 5'b10000, 1'b0, 6'b100000, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] ierBits = '0;
  logic       rxErrLvl = 0, overrunEvt = 0, rxToEvt = 0, rxDatEvt = 0;
  logic       txEmptyEvt = 0, modemEvt = 0, xoffEvt = 0, xonEvt = 0, specialEvt = 0;
  logic [1:0] flowPinN = 2'b11;
  logic       iirRd = 0, rhrRd = 0, thrWr = 0, msrRd = 0, lsrRd = 0;
  logic       irqOut;
  logic [5:0] iirData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  uart_irq_prio i_uart_irq_prio (
    .clk(clk), .rstN(rstN), .ierBits(ierBits), .rxErrLvl(rxErrLvl),
    .overrunEvt(overrunEvt), .rxToEvt(rxToEvt), .rxDatEvt(rxDatEvt),
    .txEmptyEvt(txEmptyEvt), .modemEvt(modemEvt), .xoffEvt(xoffEvt),
    .xonEvt(xonEvt), .specialEvt(specialEvt), .flowPinN(flowPinN),
    .iirRd(iirRd), .rhrRd(rhrRd), .thrWr(thrWr), .msrRd(msrRd),
    .lsrRd(lsrRd), .irqOut(irqOut), .iirData(iirData)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ierBits = v.ier;
    {rxErrLvl, overrunEvt, rxToEvt, rxDatEvt, txEmptyEvt,
     modemEvt, xoffEvt, xonEvt, specialEvt} = v.evt;
    flowPinN = v.pinN;
    {iirRd, rhrRd, thrWr, msrRd, lsrRd} = v.stb;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    vec_t idle;
    idle = '{6'h3F, 9'b0, 2'b11, 5'b0, 1'b0, 6'b0, 4'd0};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset irqOut", {5'b0, irqOut}, 6'b0);
    check("R1 reset iirData", iirData, 6'b000001);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec %0d irqOut", VECS[i].req, i), {5'b0, irqOut},
            {5'b0, VECS[i].expIrq});
      if (VECS[i].stb[4])
        check($sformatf("R%0d vec %0d iirData", VECS[i].req, i), iirData, VECS[i].expId);
    end

    // R1 reset while sources are pending wipes them
    @(negedge clk);
    drive(idle);
    txEmptyEvt = 1'b1;
    modemEvt   = 1'b1;
    @(negedge clk);
    drive(idle);
    iirRd = 1'b1;
    @(negedge clk);
    drive(idle);
    check("R1 pre-reset iirData", iirData, 6'b000010);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset irqOut cleared", {5'b0, irqOut}, 6'b0);
    check("R1 reset iirData value", iirData, 6'b000001);
    rstN = 1'b1;
    @(negedge clk);
    iirRd = 1'b1;
    @(negedge clk);
    iirRd = 1'b0;
    check("R1 post-reset read", iirData, 6'b000001);
    check("R1 post-reset irqOut", {5'b0, irqOut}, 6'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule